// File: doc/BRIEF.md
# Host Bus Chip-Select and Coprocessor Control Decoder

This block sits beside a 16-bit host processor that has a 24-bit byte address space, an address strobe, two byte-lane data strobes and a read/write line. It turns the current address into active-low selects for the cartridge connector, the expansion connector, the I/O register block and two small auxiliary pages, one on each connector. Every select is qualified by the address strobe. Each select is asserted only while a valid address is on the bus.

Two 4 MB windows at the bottom of the map belong to the two connectors. A single active-low cartridge-present input decides which connector owns which window. The block also holds two coprocessor control bits: a bus request and a reset release. Each bit is written through data bit 8 only, which is bit 0 of the even (upper) byte lane. The block acknowledges accesses to these two control pages itself. For every other region it leaves the acknowledge undriven, so the selected device must acknowledge the access.

There is no streaming interface. All pins are plain control and status lines, and there is no back-pressure. The strobes must be synchronous to `clk`.

Top module: `hostbus_select_decoder`

## Requirements
- R1: During and directly after reset, `cop_busreq_n` is 1 (bus not requested), `cop_reset_n` is 0 (coprocessor held in reset), `dtack_oe` is 0 and `rdata_oe` is 0.
- R2: With `cart_present_n` = 0, byte addresses 0x000000–0x3FFFFF assert `cart_cs_n` and 0x400000–0x7FFFFF assert `exp_cs_n`.
- R3: With `cart_present_n` = 1, the two windows swap: 0x000000–0x3FFFFF asserts `exp_cs_n` and 0x400000–0x7FFFFF asserts `cart_cs_n`.
- R4: Addresses 0xA12000–0xA12FFF assert `exp_aux_cs_n`, and addresses 0xA13000–0xA13FFF assert `cart_aux_cs_n`.
- R5: Addresses 0xA10000–0xA1001F assert `io_cs_n`. Address 0xA10020 does not.
- R6: While `as_n` is 1, every select output is 1, whatever the address.
- R7: A write (`rw` = 0) to page 0xA111xx with `uds_n` = 0 stores `wd8` at the first clock edge of the strobe. `cop_busreq_n` then equals the inverse of that bit. Control bits change at no other time.
- R8: A write to page 0xA112xx with `uds_n` = 0 stores `wd8` in the same way. `cop_reset_n` then equals that bit (1 releases the coprocessor).
- R9: A control-page write with `uds_n` = 1 (odd lane only) leaves both control bits unchanged, but it is still acknowledged.
- R10: A read (`rw` = 1) of page 0xA111xx drives `rdata_oe` = 1, with `rdata[8]` equal to `cop_busack_n` (0 when granted) and all other bits 0. A read of page 0xA112xx returns all zeros.
- R11: For control-page accesses, `dtack_oe` is 1 while `as_n` is 0. `dtack_n` goes to 0 at the first clock edge that sees a data strobe and returns to 1 at the first edge after `as_n` rises. For all other regions, `dtack_oe` stays 0.
- R12: At most one select is 0 at any time. An address outside every region asserts none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 23 | Host word address, byte address bits 23..1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Even (upper) byte lane strobe, active low |
| lds_n | input | 1 | Odd (lower) byte lane strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| wd8 | input | 1 | Data bus bit 8 |
| cart_present_n | input | 1 | Cartridge present, active low |
| cop_busack_n | input | 1 | Coprocessor bus grant, active low |
| cart_cs_n | output | 1 | Cartridge window select |
| exp_cs_n | output | 1 | Expansion window select |
| io_cs_n | output | 1 | I/O register block select |
| exp_aux_cs_n | output | 1 | Expansion auxiliary page select |
| cart_aux_cs_n | output | 1 | Cartridge auxiliary page select |
| cop_busreq_n | output | 1 | Coprocessor bus request, active low |
| cop_reset_n | output | 1 | Coprocessor reset, active low |
| rdata | output | 16 | Read data for the control pages |
| rdata_oe | output | 1 | Drive enable for `rdata` |
| dtack_n | output | 1 | Acknowledge level for the control pages |
| dtack_oe | output | 1 | Drive enable for `dtack_n` |

## Verification
The cartridge-present line can flip at the same clock edge at which a bus-request write commits. The window swap is combinational, while the control bit is registered, so the two must not interfere. The bench provokes this by toggling `cart_present_n` in the same cycle that it starts a write to 0xA111xx. After that edge it checks that the stored request bit is correct and that the window selects follow the new swap state. Both window regions and the auxiliary pages are swept over every 4 KB page, under both cartridge states, with the expected selects computed arithmetically from the address.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int ADDR_BITS = 24;

  // fixed-page region indices
  localparam int RG_IO       = 0;
  localparam int RG_EXP_AUX  = 1;
  localparam int RG_CART_AUX = 2;
  localparam int RG_BUSREQ   = 3;
  localparam int RG_CRESET   = 4;
  localparam int RG_COUNT    = 5;

  typedef struct packed {
    logic cart;
    logic expn;
    logic io;
    logic exp_aux;
    logic cart_aux;
  } sel_t;
endpackage

// File: rtl/hbd_window_map.sv
module hbd_window_map #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cart_present_n,
  output logic              cart_hit,
  output logic              exp_hit
);
  localparam int IDX_W = ADDR_W - WIN_LOG2;

  logic [1:0] win_hit;

  for (genvar k = 0; k < 2; k++) begin : g_win
    assign win_hit[k] = (addr[ADDR_W-1:WIN_LOG2] == IDX_W'(k));
  end

  // present cartridge owns the bottom window, otherwise the next one
  assign cart_hit = cart_present_n ? win_hit[1] : win_hit[0];
  assign exp_hit  = cart_present_n ? win_hit[0] : win_hit[1];
endmodule

// File: rtl/hbd_page_decode.sv
module hbd_page_decode #(
  parameter int              ADDR_W        = 24,
  parameter logic [ADDR_W-1:0] IO_BASE       = 24'hA10000,
  parameter int              IO_LOG2       = 5,
  parameter logic [ADDR_W-1:0] EXP_AUX_BASE  = 24'hA12000,
  parameter logic [ADDR_W-1:0] CART_AUX_BASE = 24'hA13000,
  parameter int              AUX_LOG2      = 12,
  parameter logic [ADDR_W-1:0] BUSREQ_BASE   = 24'hA11100,
  parameter logic [ADDR_W-1:0] CRESET_BASE   = 24'hA11200,
  parameter int              CTL_LOG2      = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic [hbd_pkg::RG_COUNT-1:0] hit
);
  import hbd_pkg::*;

  localparam logic [ADDR_W-1:0] BASES [RG_COUNT] =
    '{IO_BASE, EXP_AUX_BASE, CART_AUX_BASE, BUSREQ_BASE, CRESET_BASE};
  localparam int SPANS [RG_COUNT] =
    '{IO_LOG2, AUX_LOG2, AUX_LOG2, CTL_LOG2, CTL_LOG2};

  for (genvar r = 0; r < RG_COUNT; r++) begin : g_page
    localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << SPANS[r]) - ADDR_W'(1));
    assign hit[r] = ((addr ^ BASES[r]) & MASK) == '0;
  end
endmodule

// File: rtl/hbd_ctl_regs.sv
module hbd_ctl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic        uds_n,
  input  logic        lds_n,
  input  logic        rw,
  input  logic        wd8,
  input  logic        hit_busreq,
  input  logic        hit_creset,
  input  logic        busack_n,
  output logic        busreq,
  output logic        cop_run,
  output logic        ack,
  output logic        own_cycle,
  output logic        rd_oe,
  output logic [15:0] rd
);
  logic busreq_q, run_q, ack_q;
  logic strobe, first;

  assign own_cycle = !as_n && (hit_busreq || hit_creset);
  assign strobe    = !uds_n || !lds_n;
  assign first     = own_cycle && strobe && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busreq_q <= 1'b0;
      run_q    <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      if (as_n)
        ack_q <= 1'b0;
      else if (own_cycle && strobe)
        ack_q <= 1'b1;
      // only the even lane carries the control bit
      if (first && !rw && !uds_n) begin
        if (hit_busreq) busreq_q <= wd8;
        if (hit_creset) run_q    <= wd8;
      end
    end
  end

  assign busreq = busreq_q;
  assign cop_run = run_q;
  assign ack    = ack_q;
  assign rd_oe  = own_cycle && rw;
  assign rd     = (rd_oe && hit_busreq) ? {7'd0, busack_n, 8'd0} : 16'd0;
endmodule

// File: rtl/hostbus_select_decoder.sv
module hostbus_select_decoder #(
  parameter int ADDR_W   = hbd_pkg::ADDR_BITS,
  parameter int WIN_LOG2 = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  input  logic              wd8,
  input  logic              cart_present_n,
  input  logic              cop_busack_n,
  output logic              cart_cs_n,
  output logic              exp_cs_n,
  output logic              io_cs_n,
  output logic              exp_aux_cs_n,
  output logic              cart_aux_cs_n,
  output logic              cop_busreq_n,
  output logic              cop_reset_n,
  output logic [15:0]       rdata,
  output logic              rdata_oe,
  output logic              dtack_n,
  output logic              dtack_oe
);
  import hbd_pkg::*;

  logic [ADDR_W-1:0]   byte_addr;
  logic                cart_hit, exp_hit;
  logic [RG_COUNT-1:0] page_hit;
  sel_t                raw, qual;
  logic                busreq, cop_run, ack, own_cycle;

  assign byte_addr = {addr_i, 1'b0};

  hbd_window_map #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .addr(byte_addr), .cart_present_n(cart_present_n),
    .cart_hit(cart_hit), .exp_hit(exp_hit)
  );

  hbd_page_decode #(.ADDR_W(ADDR_W)) u_page (
    .addr(byte_addr), .hit(page_hit)
  );

  hbd_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .wd8(wd8),
    .hit_busreq(page_hit[RG_BUSREQ]), .hit_creset(page_hit[RG_CRESET]),
    .busack_n(cop_busack_n),
    .busreq(busreq), .cop_run(cop_run), .ack(ack), .own_cycle(own_cycle),
    .rd_oe(rdata_oe), .rd(rdata)
  );

  always_comb begin
    raw.cart     = cart_hit;
    raw.expn     = exp_hit;
    raw.io       = page_hit[RG_IO];
    raw.exp_aux  = page_hit[RG_EXP_AUX];
    raw.cart_aux = page_hit[RG_CART_AUX];
    qual         = as_n ? '0 : raw;
  end

  assign cart_cs_n     = !qual.cart;
  assign exp_cs_n      = !qual.expn;
  assign io_cs_n       = !qual.io;
  assign exp_aux_cs_n  = !qual.exp_aux;
  assign cart_aux_cs_n = !qual.cart_aux;
  assign cop_busreq_n  = !busreq;
  assign cop_reset_n   = cop_run;
  assign dtack_n       = !ack;
  assign dtack_oe      = own_cycle;
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        as_n,
  input logic        cart_cs_n,
  input logic        exp_cs_n,
  input logic        io_cs_n,
  input logic        exp_aux_cs_n,
  input logic        cart_aux_cs_n,
  input logic        cop_busreq_n,
  input logic        cop_reset_n,
  input logic [15:0] rdata,
  input logic        rdata_oe,
  input logic        dtack_oe
);
  logic [4:0] sels_n;
  assign sels_n = {cart_cs_n, exp_cs_n, io_cs_n, exp_aux_cs_n, cart_aux_cs_n};

  always_comb begin
    if (rst_n == 1'b0)
      a_reset_r1: assert (cop_busreq_n && !cop_reset_n && !dtack_oe);
  end

  p_as_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (sels_n == 5'b11111));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sels_n) <= 1);

  p_ext_noack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sels_n != 5'b11111) |-> !dtack_oe);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n) |-> ($stable(cop_busreq_n) && $stable(cop_reset_n)));

  p_read_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (dtack_oe && ((rdata & 16'hFEFF) == 16'h0000)));
endmodule

bind hostbus_select_decoder hbd_checker u_hbd_checker (
  .clk(clk), .rst_n(rst_n), .as_n(as_n),
  .cart_cs_n(cart_cs_n), .exp_cs_n(exp_cs_n), .io_cs_n(io_cs_n),
  .exp_aux_cs_n(exp_aux_cs_n), .cart_aux_cs_n(cart_aux_cs_n),
  .cop_busreq_n(cop_busreq_n), .cop_reset_n(cop_reset_n),
  .rdata(rdata), .rdata_oe(rdata_oe), .dtack_oe(dtack_oe)
);

// File: tb/hostbus_select_decoder_test.sv
module hostbus_select_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] addr_i = '0;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, wd8 = 1'b0;
  logic        cart_present_n = 1'b0, cop_busack_n = 1'b1;
  logic        cart_cs_n, exp_cs_n, io_cs_n, exp_aux_cs_n, cart_aux_cs_n;
  logic        cop_busreq_n, cop_reset_n, rdata_oe, dtack_n, dtack_oe;
  logic [15:0] rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hostbus_select_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw(rw), .wd8(wd8), .cart_present_n(cart_present_n),
    .cop_busack_n(cop_busack_n), .cart_cs_n(cart_cs_n), .exp_cs_n(exp_cs_n),
    .io_cs_n(io_cs_n), .exp_aux_cs_n(exp_aux_cs_n), .cart_aux_cs_n(cart_aux_cs_n),
    .cop_busreq_n(cop_busreq_n), .cop_reset_n(cop_reset_n), .rdata(rdata),
    .rdata_oe(rdata_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected selects {cart,exp,io,exp_aux,cart_aux}, active low
  function automatic logic [4:0] exp_sel(input logic [23:0] a, input logic cp_n, input logic asn);
    logic [1:0] win;
    logic c, e, i, xa, ca;
    win = a[23:22];
    c  = (win == 2'd0 && !cp_n) || (win == 2'd1 && cp_n);
    e  = (win == 2'd1 && !cp_n) || (win == 2'd0 && cp_n);
    i  = (a >= 24'hA10000) && (a <= 24'hA1001F);
    xa = (a >= 24'hA12000) && (a <= 24'hA12FFF);
    ca = (a >= 24'hA13000) && (a <= 24'hA13FFF);
    if (asn) return 5'b11111;
    return ~{c, e, i, xa, ca};
  endfunction

  function automatic logic [4:0] sel_now();
    return {cart_cs_n, exp_cs_n, io_cs_n, exp_aux_cs_n, cart_aux_cs_n};
  endfunction

  task automatic probe(input string req, input logic [23:0] a, input logic cp_n, input logic asn);
    addr_i = a[23:1];
    cart_present_n = cp_n;
    as_n = asn;
    #0.5;
    chk(req, {27'd0, sel_now()}, {27'd0, exp_sel(a, cp_n, asn)});
  endtask

  // begin an access at a falling edge; return after the next rising edge
  task automatic begin_acc(input logic [23:0] a, input logic wr, input logic b8,
                           input logic u, input logic l);
    @(negedge clk);
    addr_i = a[23:1]; rw = !wr; wd8 = b8; uds_n = !u; lds_n = !l; as_n = 1'b0;
    #0.5;
    chk("R11 ack not before edge", {31'd0, dtack_n}, 32'd1);
    @(negedge clk);
  endtask

  task automatic end_acc();
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
    @(negedge clk);
    chk("R11 ack released", {31'd0, dtack_n}, 32'd1);
    chk("R11 oe released", {31'd0, dtack_oe}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busreq_n", {31'd0, cop_busreq_n}, 32'd1);
    chk("R1 reset_n", {31'd0, cop_reset_n}, 32'd0);
    chk("R1 dtack_oe", {31'd0, dtack_oe}, 32'd0);
    chk("R1 rdata_oe", {31'd0, rdata_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {30'd0, cop_busreq_n, cop_reset_n}, 32'd2);

    // R2 R3 R4 R12: every 4 KB page, both cartridge states
    for (int cp = 0; cp < 2; cp++)
      for (int pg = 0; pg < 4096; pg++)
        probe(cp ? "R3 R4 R12 page sweep" : "R2 R4 R12 page sweep",
              {pg[11:0], 12'h010}, cp[0], 1'b0);
    // R6 strobe gating
    for (int pg = 0; pg < 4096; pg += 7)
      probe("R6 no select without AS", {pg[11:0], 12'h000}, pg[0], 1'b1);
    // R5 I/O boundaries
    probe("R5 io first", 24'hA10000, 1'b0, 1'b0);
    probe("R5 io last", 24'hA1001E, 1'b0, 1'b0);
    probe("R5 io beyond", 24'hA10020, 1'b0, 1'b0);
    probe("R12 unmatched", 24'hA11100, 1'b0, 1'b0);
    probe("R12 unmatched high", 24'hFF0000, 1'b1, 1'b0);
    probe("R2 window edge", 24'h3FFFFE, 1'b0, 1'b0);
    probe("R3 window edge", 24'h400000, 1'b1, 1'b0);
    as_n = 1'b1;

    // R7 request write, with cart_present_n flipping in the same cycle
    @(negedge clk);
    addr_i = 24'hA11100 >> 1; rw = 1'b0; wd8 = 1'b1; uds_n = 1'b0; as_n = 1'b0;
    cart_present_n = 1'b1;
    @(negedge clk);
    chk("R7 request stored", {31'd0, cop_busreq_n}, 32'd0);
    chk("R11 ack asserted", {30'd0, dtack_oe, dtack_n}, 32'd2);
    end_acc();
    probe("R3 swap after concurrent write", 24'h000400, 1'b1, 1'b0);
    as_n = 1'b1;

    // R9 odd-lane write ignored
    begin_acc(24'hA11100, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 odd lane acked", {30'd0, dtack_oe, dtack_n}, 32'd2);
    end_acc();
    chk("R9 request kept", {31'd0, cop_busreq_n}, 32'd0);
    begin_acc(24'hA11200, 1'b1, 1'b1, 1'b0, 1'b1);
    end_acc();
    chk("R9 reset kept", {31'd0, cop_reset_n}, 32'd0);

    // R8 reset release then hold
    begin_acc(24'hA11200, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R8 release", {31'd0, cop_reset_n}, 32'd1);
    chk("R7 request untouched by reset page", {31'd0, cop_busreq_n}, 32'd0);
    end_acc();

    // R10 reads
    cop_busack_n = 1'b0;
    begin_acc(24'hA11100, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 granted read", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, 16'h0000});
    cop_busack_n = 1'b1;
    #0.5;
    chk("R10 not granted read", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, 16'h0100});
    end_acc();
    begin_acc(24'hA11200, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 reset page reads zero", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, 16'h0000});
    end_acc();

    // R7 clear request, R8 hold again
    begin_acc(24'hA11100, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7 request cleared", {31'd0, cop_busreq_n}, 32'd1);
    end_acc();
    begin_acc(24'hA11200, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 hold", {31'd0, cop_reset_n}, 32'd0);
    end_acc();

    // R11 external regions not acknowledged
    begin_acc(24'h000100, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 external no ack", {31'd0, dtack_oe}, 32'd0);
    end_acc();
    begin_acc(24'hA10004, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R11 io no ack", {31'd0, dtack_oe}, 32'd0);
    end_acc();

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule